// File: doc/BRIEF.md
# ECC Error Event Logger

This block records DRAM error-correction events reported by two memory channels. Each channel can report a correctable (single-bit) or an uncorrectable (multi-bit) event. Each event carries the rank, bank, row, column and syndrome of the failing access. The block keeps one 64-bit log per channel and one shared 16-bit summary status word. Software reads them through a simple register port and clears flags by writing ones to them.

Logging follows a fixed priority. An empty log takes the first event it sees. An uncorrectable event replaces a log that holds only a correctable record. Nothing else replaces a valid log until software clears that log's flags. A mode input turns the block into a single-channel logger, in which channel 1 is ignored.

Top module: `ecc_err_logger`

## Requirements
- R1: After reset, the status word and both logs read as zero.
- R2: A correctable event on an active channel sets status bit 0, and an uncorrectable event sets status bit 1. The new value is readable at address 0 from the next clock edge. Status bits 15:2 always read zero.
- R3: A write to address 0 clears each status bit whose write-data bit is 1 and leaves the others unchanged. If an event sets a bit in the same cycle as a write clears it, the bit ends up set.
- R4: A captured log word holds column in [63:48], row in [47:32], bank in [31:29], rank in [28:27] and syndrome in [23:16]. It holds the uncorrectable flag in [1] and the correctable flag in [0]. Bits [26:24] and [15:2] are zero. The syndrome is stored for both event kinds.
- R5: A correctable event is captured only into an empty log, meaning both flags are 0. An existing record is left unchanged.
- R6: An uncorrectable event replaces a log holding a correctable record. The log then reads flag bits 2'b10 with the new fields. An uncorrectable event never replaces an existing uncorrectable record.
- R7: When a channel reports both kinds in the same cycle, only the uncorrectable one is logged.
- R8: A write to address 1 (channel 0) or address 2 (channel 1) clears the log flag bits whose write-data bits [1:0] are 1. A log with both flags clear can capture again. An event in the same cycle as the clear is logged as if the log were already cleared.
- R9: While single_mode is 1, channel 1 events change neither the channel 1 log nor the status word.
- R10: Address 3 reads zero. Write-data bits other than [1:0] have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| single_mode | input | 1 | 1: only channel 0 is logged |
| ev_ce | input | 2 | Correctable event pulse per channel |
| ev_ue | input | 2 | Uncorrectable event pulse per channel |
| ev_rank | input | 2x2 | Rank of the event per channel |
| ev_bank | input | 2x3 | Bank per channel |
| ev_row | input | 2x16 | Row per channel |
| ev_col | input | 2x16 | Column per channel |
| ev_syn | input | 2x8 | Syndrome per channel |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 status, 1 log ch0, 2 log ch1, 3 none |
| reg_wdata | input | 64 | Write data (bits [1:0] used) |
| reg_rdata | output | 64 | Read data for reg_addr, combinational |

## Verification
Every event and every write takes effect at one clock edge, and its result shows on the read port in the same cycle. The read path is combinational on the address. The bench therefore drives stimulus at a falling edge and waits through one rising edge. At the next falling edge it removes the stimulus, then reads each address in turn and compares. Each table step checks the status and the flag bits of both logs. Directed steps then check full log words, including the field positions, the priority cases and the unused address.

// File: rtl/ecc_err_logger.sv
module ecc_err_logger #(
  parameter int NCH = 2,
  parameter int AW  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  single_mode,
  input  logic [NCH-1:0]        ev_ce,
  input  logic [NCH-1:0]        ev_ue,
  input  logic [NCH-1:0][1:0]   ev_rank,
  input  logic [NCH-1:0][2:0]   ev_bank,
  input  logic [NCH-1:0][15:0]  ev_row,
  input  logic [NCH-1:0][15:0]  ev_col,
  input  logic [NCH-1:0][7:0]   ev_syn,
  input  logic                  reg_we,
  input  logic [AW-1:0]         reg_addr,
  input  logic [63:0]           reg_wdata,
  output logic [63:0]           reg_rdata
);
  logic [15:0]    stat;
  logic [63:0]    lg    [NCH];
  logic [NCH-1:0] ce_a, ue_a;

  wire [1:0] st_clr = (reg_we && reg_addr == '0) ? reg_wdata[1:0] : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) stat <= '0;
    else        stat <= {14'b0, (stat[1:0] & ~st_clr) | {|ue_a, |ce_a}};
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    wire act = (c == 0) || !single_mode;
    assign ce_a[c] = ev_ce[c] & act;
    assign ue_a[c] = ev_ue[c] & act;
    wire [1:0]  clr  = (reg_we && reg_addr == AW'(c + 1)) ? reg_wdata[1:0] : 2'b00;
    wire [63:0] base = {lg[c][63:2], lg[c][1:0] & ~clr};
    wire [63:0] rec  = {ev_col[c], ev_row[c], ev_bank[c], ev_rank[c], 3'b0,
                        ev_syn[c], 16'b0};

    always_ff @(posedge clk) begin
      if (!rst_n)                            lg[c] <= '0;
      else if (ue_a[c] && !base[1])          lg[c] <= rec | 64'd2;
      else if (ce_a[c] && base[1:0] == 2'b0) lg[c] <= rec | 64'd1;
      else                                   lg[c] <= base;
    end

    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      lg[c][26:24] == 3'b0 && lg[c][15:2] == 14'b0);
    a_r6_ue_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (lg[c][1] && !clr[1]) |=> lg[c][1]);
    a_r5_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
      ((lg[c][1:0] != 2'b0) && clr == 2'b0 && !ev_ue[c]) |=> $stable(lg[c]));
    a_r7_ue_first: assert property (@(posedge clk) disable iff (!rst_n)
      (ue_a[c] && lg[c][1:0] == 2'b0) |=> lg[c][1:0] == 2'b10);
    if (c > 0) begin : g_single
      a_r9_single_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (single_mode && clr == 2'b0) |=> $stable(lg[c]));
    end
  end

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    stat[15:2] == 14'b0);
  a_r3_w1c_only: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[1] && !st_clr[1]) |=> stat[1]);
  a_r3_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|ce_a) |=> stat[0]);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == '0)                        reg_rdata = {48'b0, stat};
    else if (int'(reg_addr) <= NCH)            reg_rdata = lg[int'(reg_addr) - 1];
  end
endmodule

// File: tb/sim_ecc_err_logger.sv
module sim_ecc_err_logger;
  logic clk = 0, rst_n = 0, single_mode = 0;
  logic [1:0] ev_ce = 0, ev_ue = 0;
  logic [1:0][1:0]  ev_rank = '0;
  logic [1:0][2:0]  ev_bank = '0;
  logic [1:0][15:0] ev_row = '0, ev_col = '0;
  logic [1:0][7:0]  ev_syn = '0;
  logic reg_we = 0;
  logic [1:0] reg_addr = 0;
  logic [63:0] reg_wdata = 0, reg_rdata;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  ecc_err_logger u0 (.*);

  // {ce0,ue0,ce1,ue1}, we, addr, wbits, single, exp status, exp log0 flags, exp log1 flags
  localparam logic [15:0] VEC [16] = '{
    {4'b1000, 1'b0, 2'd0, 2'b00, 1'b0, 2'b01, 2'b01, 2'b00},
    {4'b0010, 1'b0, 2'd0, 2'b00, 1'b0, 2'b01, 2'b01, 2'b01},
    {4'b1000, 1'b0, 2'd0, 2'b00, 1'b0, 2'b01, 2'b01, 2'b01},
    {4'b0100, 1'b0, 2'd0, 2'b00, 1'b0, 2'b11, 2'b10, 2'b01},
    {4'b1000, 1'b0, 2'd0, 2'b00, 1'b0, 2'b11, 2'b10, 2'b01},
    {4'b0000, 1'b1, 2'd0, 2'b01, 1'b0, 2'b10, 2'b10, 2'b01},
    {4'b0000, 1'b1, 2'd0, 2'b00, 1'b0, 2'b10, 2'b10, 2'b01},
    {4'b0000, 1'b1, 2'd1, 2'b10, 1'b0, 2'b10, 2'b00, 2'b01},
    {4'b1000, 1'b1, 2'd0, 2'b11, 1'b0, 2'b01, 2'b01, 2'b01},
    {4'b0011, 1'b0, 2'd0, 2'b00, 1'b0, 2'b11, 2'b01, 2'b10},
    {4'b0000, 1'b1, 2'd2, 2'b11, 1'b0, 2'b11, 2'b01, 2'b00},
    {4'b0011, 1'b0, 2'd0, 2'b00, 1'b1, 2'b11, 2'b01, 2'b00},
    {4'b0000, 1'b1, 2'd0, 2'b11, 1'b1, 2'b00, 2'b01, 2'b00},
    {4'b0100, 1'b0, 2'd0, 2'b00, 1'b1, 2'b10, 2'b10, 2'b00},
    {4'b1000, 1'b1, 2'd1, 2'b11, 1'b0, 2'b11, 2'b01, 2'b00},
    {4'b0010, 1'b1, 2'd2, 2'b11, 1'b0, 2'b11, 2'b01, 2'b01}
  };
  localparam string VREQ [16] = '{"R2", "R2", "R5", "R6", "R5", "R3", "R3", "R8",
                                  "R3", "R7", "R8", "R9", "R3", "R9", "R8", "R8"};

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [63:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    ev_ce = 0; ev_ue = 0; reg_we = 0; reg_wdata = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < 3; a++) begin
      rd(2'(a), d); check("R1", d, 64'h0);
    end

    for (int i = 0; i < 16; i++) begin
      {ev_ce[0], ev_ue[0], ev_ce[1], ev_ue[1]} = VEC[i][15:12];
      reg_we = VEC[i][11]; reg_addr = VEC[i][10:9];
      reg_wdata = {62'h0, VEC[i][8:7]};
      single_mode = VEC[i][6];
      ev_syn[0] = 8'(i); ev_syn[1] = 8'(i + 32);
      step();
      rd(2'd0, d); check(VREQ[i], d, {60'h0, 2'b00, VEC[i][5:4]});
      rd(2'd1, d); check(VREQ[i], {62'h0, d[1:0]}, {62'h0, VEC[i][3:2]});
      rd(2'd2, d); check(VREQ[i], {62'h0, d[1:0]}, {62'h0, VEC[i][1:0]});
    end

    // clear everything, then field placement checks
    single_mode = 0;
    reg_we = 1; reg_addr = 1; reg_wdata = 64'h3; step();
    reg_we = 1; reg_addr = 2; reg_wdata = 64'h3; step();
    reg_we = 1; reg_addr = 0; reg_wdata = 64'hFFFF_FFFF_FFFF_FFFF; step();
    rd(2'd0, d); check("R10", d, 64'h0);

    ev_rank[0] = 2; ev_bank[0] = 5; ev_row[0] = 16'h1234; ev_col[0] = 16'hABCD;
    ev_syn[0] = 8'h5A; ev_ce[0] = 1; step();
    rd(2'd1, d); check("R4", d, 64'hABCD_1234_B05A_0001);

    ev_rank[0] = 1; ev_bank[0] = 7; ev_row[0] = 16'h7777; ev_col[0] = 16'h1111;
    ev_syn[0] = 8'h22; ev_ce[0] = 1; step();
    rd(2'd1, d); check("R5", d, 64'hABCD_1234_B05A_0001);

    ev_rank[0] = 1; ev_bank[0] = 3; ev_row[0] = 16'h0F0F; ev_col[0] = 16'h00FF;
    ev_syn[0] = 8'h11; ev_ue[0] = 1; step();
    rd(2'd1, d); check("R6", d, 64'h00FF_0F0F_6811_0002);

    ev_rank[0] = 3; ev_row[0] = 16'hDEAD; ev_ue[0] = 1; step();
    rd(2'd1, d); check("R6", d, 64'h00FF_0F0F_6811_0002);

    rd(2'd3, d); check("R10", d, 64'h0);
    rd(2'd0, d); check("R2", d, 64'h3);

    reg_we = 1; reg_addr = 1; reg_wdata = 64'hFFFF_FFFF_FFFF_FFFE; step();
    rd(2'd1, d); check("R8", d, 64'h00FF_0F0F_6811_0000);

    ev_rank[1] = 3; ev_bank[1] = 1; ev_row[1] = 16'h0001; ev_col[1] = 16'h8000;
    ev_syn[1] = 8'hC3; ev_ce[1] = 1; ev_ue[1] = 1; step();
    rd(2'd2, d); check("R7", d, 64'h8000_0001_38C3_0002);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule